// File: doc/BRIEF.md
# Fetch Loop Replay Buffer

This block sits beside an instruction fetch stage and holds the body of a small loop so that fetch can stop going to memory while the loop runs. The commit side reports a detected loop by pulsing a detect input together with the address of the backward branch that closes the loop. The buffer then watches the fetched stream for that branch. Once it sees the branch taken, it records every following fetched instruction (address and raw encoding) up to and including the next taken occurrence of the same branch. From then on it plays the recorded body back in order, over and over, and raises a hold flag that tells fetch to issue no more memory requests.

Entries keep the undecoded instruction word, so replayed instructions still go through pre-decode and prediction downstream, exactly as freshly fetched ones do. A flush (for example a mispredicted exit from the loop) returns the block to its idle state. A stalled output freezes the block for that cycle.

Top module: `loop_replay_buffer`

## Requirements
- R1: After reset the block is idle: `rp_valid` and `fetch_hold` are 0.
- R2: In idle, `loop_seen` high for one cycle latches `loop_br_pc` as the loop branch and starts watching the fetched stream. `fetch_hold` stays 0 until a complete body has been recorded.
- R3: While watching, only a fetched instruction with `fe_pc` equal to the latched branch and `fe_taken` = 1 starts recording. A not-taken match or any other address does nothing. Recording begins with the next valid fetched instruction.
- R4: While recording, each valid fetched instruction is stored in arrival order, the closing branch included. A taken fetch of the loop branch ends recording. From the next cycle `fetch_hold` = 1 and replay starts.
- R5: During replay, entries are presented one per unstalled cycle in stored order, starting from the first. After the closing branch, the next entry presented is the first one again.
- R6: Each replayed entry carries the exact address and raw encoding word that were fetched, with no change.
- R7: The number of entries is the parameter `DEPTH`. A body of exactly `DEPTH` instructions is replayed in full. A valid fetch arriving while all `DEPTH` entries are used abandons the recording and returns to idle, with no replay.
- R8: While `out_stall` = 1 (and no flush), `rp_valid` = 0. The state, the replay position and the stored entries do not change, and fetched instructions and `loop_seen` are ignored.
- R9: `flush` has priority over everything. It returns the block to idle from any state on the next cycle and discards any partial recording. `rp_valid` is 0 in the flush cycle.
- R10: While recording, a fetch of the loop branch with `fe_taken` = 0 means the loop was left. The block returns to idle.
- R11: `loop_seen` outside the idle state has no effect.
- R12: During replay, the fetched stream inputs have no effect on the replayed entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_seen | input | 1 | Loop detected by the commit side |
| loop_br_pc | input | PC_W | Address of the branch closing the detected loop |
| fe_valid | input | 1 | Fetched instruction present |
| fe_pc | input | PC_W | Address of the fetched instruction |
| fe_word | input | WORD_W | Raw encoding of the fetched instruction |
| fe_taken | input | 1 | Fetched instruction predicted taken |
| flush | input | 1 | Pipeline flush |
| out_stall | input | 1 | Downstream cannot accept this cycle |
| rp_valid | output | 1 | Replayed entry present |
| rp_pc | output | PC_W | Address of the replayed entry |
| rp_word | output | WORD_W | Raw encoding of the replayed entry |
| fetch_hold | output | 1 | Fetch must not issue memory requests |

## Verification
The properties assume that a detect pulse arrives only while the fetched stream is consistent with the reported branch, and that the closing branch reaches the buffer as a taken fetch while the loop runs. The stimulus is built from hand-written address sequences that follow a real loop shape: a few straight-line addresses, then the branch.

Departures from that shape are made only on purpose, to reach the defined fallbacks: a not-taken closing branch, a body one entry too long, a flush during recording, and stray inputs during replay. Every replay check compares against address and encoding values that the bench derives from its own loop model.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

  typedef enum logic [1:0] {
    LB_IDLE   = 2'd0,
    LB_WAIT   = 2'd1,
    LB_FILL   = 2'd2,
    LB_SUPPLY = 2'd3
  } lb_state_e;

  // Slot following ptr within a body of len entries, wrapping to zero.
  function automatic int unsigned lb_next_slot(int unsigned ptr, int unsigned len);
    return (ptr + 1 >= len) ? 0 : ptr + 1;
  endfunction

  // True when the recorded count already uses every entry.
  function automatic logic lb_is_full(int unsigned cnt, int unsigned depth);
    return cnt >= depth;
  endfunction

endpackage

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl
  import lbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loop_seen,
  input  logic [PC_W-1:0]  loop_br_pc,
  input  logic             fe_valid,
  input  logic [PC_W-1:0]  fe_pc,
  input  logic             fe_taken,
  input  logic             flush,
  input  logic             out_stall,
  output lb_state_e        state,
  output logic [CNT_W-1:0] fill_cnt,
  output logic [CNT_W-1:0] body_len,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx
);

  lb_state_e        state_q, state_d;
  logic [PC_W-1:0]  target_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, len_q, len_d;
  logic             live;
  logic             br_hit;
  logic             full;

  assign live   = !out_stall && !flush;
  assign br_hit = fe_valid && (fe_pc == target_q);
  assign full   = lb_is_full(32'(cnt_q), 32'(DEPTH));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    wr_en   = 1'b0;
    if (flush) begin
      state_d = LB_IDLE;
      cnt_d   = '0;
    end else if (!out_stall) begin
      unique case (state_q)
        LB_IDLE: begin
          if (loop_seen) state_d = LB_WAIT;
        end
        LB_WAIT: begin
          if (br_hit && fe_taken) begin
            state_d = LB_FILL;
            cnt_d   = '0;
          end
        end
        LB_FILL: begin
          if (fe_valid) begin
            if (full) begin
              state_d = LB_IDLE;
              cnt_d   = '0;
            end else begin
              wr_en = 1'b1;
              if (br_hit && fe_taken) begin
                state_d = LB_SUPPLY;
                len_d   = CNT_W'(cnt_q + 1'b1);
                cnt_d   = CNT_W'(cnt_q + 1'b1);
              end else if (br_hit) begin
                state_d = LB_IDLE;
                cnt_d   = '0;
              end else begin
                cnt_d = CNT_W'(cnt_q + 1'b1);
              end
            end
          end
        end
        LB_SUPPLY: begin
          state_d = LB_SUPPLY;
        end
        default: state_d = LB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LB_IDLE;
      cnt_q    <= '0;
      len_q    <= '0;
      target_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      if (live && state_q == LB_IDLE && loop_seen) target_q <= loop_br_pc;
    end
  end

  assign state    = state_q;
  assign fill_cnt = cnt_q;
  assign body_len = len_q;
  assign wr_idx   = cnt_q[IDX_W-1:0];

  logic unused_ok;
  assign unused_ok = live;

endmodule

// File: rtl/lbuf_store.sv
module lbuf_store #(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PC_W-1:0]   wr_pc,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PC_W-1:0]   rd_pc,
  output logic [WORD_W-1:0] rd_word
);

  logic [PC_W-1:0]   pc_vec   [DEPTH];
  logic [WORD_W-1:0] word_vec [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [PC_W-1:0]   pc_q;
    logic [WORD_W-1:0] word_q;
    logic              sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q   <= '0;
        word_q <= '0;
      end else if (sel) begin
        pc_q   <= wr_pc;
        word_q <= wr_word;
      end
    end
    assign pc_vec[g]   = pc_q;
    assign word_vec[g] = word_q;
  end

  assign rd_pc   = pc_vec[rd_idx];
  assign rd_word = word_vec[rd_idx];

endmodule

// File: rtl/lbuf_reader.sv
module lbuf_reader
  import lbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lb_state_e        state,
  input  logic [CNT_W-1:0] body_len,
  input  logic             flush,
  input  logic             out_stall,
  output logic             rd_fire,
  output logic [IDX_W-1:0] rd_ptr
);

  logic [IDX_W-1:0] ptr_q;

  assign rd_fire = (state == LB_SUPPLY) && !out_stall && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (flush || state != LB_SUPPLY) begin
      ptr_q <= '0;
    end else if (rd_fire) begin
      ptr_q <= IDX_W'(lb_next_slot(32'(ptr_q), 32'(body_len)));
    end
  end

  assign rd_ptr = ptr_q;

endmodule

// File: rtl/loop_replay_buffer.sv
module loop_replay_buffer
  import lbuf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_seen,
  input  logic [PC_W-1:0]   loop_br_pc,
  input  logic              fe_valid,
  input  logic [PC_W-1:0]   fe_pc,
  input  logic [WORD_W-1:0] fe_word,
  input  logic              fe_taken,
  input  logic              flush,
  input  logic              out_stall,
  output logic              rp_valid,
  output logic [PC_W-1:0]   rp_pc,
  output logic [WORD_W-1:0] rp_word,
  output logic              fetch_hold
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  lb_state_e        state_q;
  logic [CNT_W-1:0] fill_cnt;
  logic [CNT_W-1:0] len_q;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             rd_fire;
  logic [IDX_W-1:0] rd_ptr;

  lbuf_ctrl #(.DEPTH(DEPTH), .PC_W(PC_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .loop_seen  (loop_seen),
    .loop_br_pc (loop_br_pc),
    .fe_valid   (fe_valid),
    .fe_pc      (fe_pc),
    .fe_taken   (fe_taken),
    .flush      (flush),
    .out_stall  (out_stall),
    .state      (state_q),
    .fill_cnt   (fill_cnt),
    .body_len   (len_q),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx)
  );

  lbuf_store #(.DEPTH(DEPTH), .PC_W(PC_W), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_pc   (fe_pc),
    .wr_word (fe_word),
    .rd_idx  (rd_ptr),
    .rd_pc   (rp_pc),
    .rd_word (rp_word)
  );

  lbuf_reader #(.DEPTH(DEPTH)) u_reader (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .body_len  (len_q),
    .flush     (flush),
    .out_stall (out_stall),
    .rd_fire   (rd_fire),
    .rd_ptr    (rd_ptr)
  );

  assign rp_valid   = rd_fire;
  assign fetch_hold = (state_q == LB_SUPPLY);

endmodule

// File: rtl/lbuf_checker.sv
module lbuf_checker
  import lbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             out_stall,
  input logic             rp_valid,
  input logic             fetch_hold,
  input lb_state_e        state_q,
  input logic [CNT_W-1:0] fill_cnt,
  input logic [CNT_W-1:0] len_q,
  input logic [IDX_W-1:0] rd_ptr,
  input logic             wr_en
);

  // R4
  replay_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rp_valid |-> fetch_hold);

  // R4
  replay_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LB_SUPPLY) |-> (len_q != '0 && len_q <= CNT_W'(DEPTH)));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_valid && 32'(rd_ptr) + 1 == 32'(len_q)) |=> (rd_ptr == '0));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(DEPTH));

  // R8
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stall && !flush) |=> ($stable(state_q) && $stable(rd_ptr) && $stable(fill_cnt)));

  // R8
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_stall |-> (!rp_valid && !wr_en));

  // R9
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (state_q == LB_IDLE && fill_cnt == '0 && !fetch_hold));

endmodule

bind loop_replay_buffer lbuf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .out_stall  (out_stall),
  .rp_valid   (rp_valid),
  .fetch_hold (fetch_hold),
  .state_q    (state_q),
  .fill_cnt   (fill_cnt),
  .len_q      (len_q),
  .rd_ptr     (rd_ptr),
  .wr_en      (wr_en)
);

// File: tb/sim_loop_replay_buffer.sv
`timescale 1ns/1ps
module sim_loop_replay_buffer;

  localparam int DEPTH = 8;
  localparam int PC_W = 32;
  localparam int WORD_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop_seen = 1'b0;
  logic [PC_W-1:0] loop_br_pc = '0;
  logic fe_valid = 1'b0;
  logic [PC_W-1:0] fe_pc = '0;
  logic [WORD_W-1:0] fe_word = '0;
  logic fe_taken = 1'b0;
  logic flush = 1'b0;
  logic out_stall = 1'b0;
  logic rp_valid;
  logic [PC_W-1:0] rp_pc;
  logic [WORD_W-1:0] rp_word;
  logic fetch_hold;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  loop_replay_buffer #(.DEPTH(DEPTH), .PC_W(PC_W), .WORD_W(WORD_W)) u0 (
    .clk(clk), .rst_n(rst_n), .loop_seen(loop_seen), .loop_br_pc(loop_br_pc),
    .fe_valid(fe_valid), .fe_pc(fe_pc), .fe_word(fe_word), .fe_taken(fe_taken),
    .flush(flush), .out_stall(out_stall), .rp_valid(rp_valid), .rp_pc(rp_pc),
    .rp_word(rp_word), .fetch_hold(fetch_hold)
  );

  // Bench-side encoding model: an arbitrary but distinct word per address.
  function automatic logic [WORD_W-1:0] word_of(logic [PC_W-1:0] pc);
    return {pc[15:0] ^ 16'h5A3C, ~pc[15:0]};
  endfunction

  typedef struct packed {
    logic        fl;
    logic        st;
    logic        fd;
    logic        v;
    logic        t;
    logic [15:0] pc;
    logic        ov;
    logic        hold;
    logic [15:0] epc;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0100, 1'b0,1'b0,16'h0000}, // R2 detect
    '{1'b0,1'b0,1'b0,1'b1,1'b0,16'h00F8, 1'b0,1'b0,16'h0000}, // R3 other pc
    '{1'b0,1'b0,1'b0,1'b1,1'b1,16'h0100, 1'b0,1'b0,16'h0000}, // R3 branch taken
    '{1'b0,1'b0,1'b0,1'b1,1'b0,16'h00F4, 1'b0,1'b0,16'h0000}, // R4
    '{1'b0,1'b0,1'b0,1'b1,1'b0,16'h00F8, 1'b0,1'b0,16'h0000}, // R4
    '{1'b0,1'b1,1'b0,1'b1,1'b0,16'h00FC, 1'b0,1'b0,16'h0000}, // R8 ignored
    '{1'b0,1'b0,1'b0,1'b1,1'b0,16'h00FC, 1'b0,1'b0,16'h0000}, // R4
    '{1'b0,1'b0,1'b0,1'b1,1'b1,16'h0100, 1'b0,1'b0,16'h0000}, // R4 close
    '{1'b0,1'b0,1'b0,1'b1,1'b0,16'h0200, 1'b1,1'b1,16'h00F4}, // R12 R5
    '{1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b1,16'h00F8}, // R5
    '{1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b1,16'h0000}, // R8
    '{1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b1,16'h00FC}, // R8 resume
    '{1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b1,16'h0100}, // R5
    '{1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b1,16'h00F4}, // R5 wrap
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0300, 1'b1,1'b1,16'h00F8}, // R11
    '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b1,16'h0000}, // R9
    '{1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0,16'h0000}  // R9 idle
  };

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive one cycle's inputs just after a falling edge, then let them settle.
  task automatic put(logic fl, logic st, logic fd, logic [PC_W-1:0] br,
                     logic v, logic t, logic [PC_W-1:0] pc);
    flush = fl; out_stall = st; loop_seen = fd; loop_br_pc = br;
    fe_valid = v; fe_taken = t; fe_pc = pc; fe_word = word_of(pc);
    #2;
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic fetch(logic [PC_W-1:0] pc, logic t);
    put(1'b0, 1'b0, 1'b0, '0, 1'b1, t, pc);
    nxt();
  endtask

  task automatic idle_cycle();
    put(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
  endtask

  task automatic expect_entry(string req, logic [PC_W-1:0] pc);
    check(req, "rp_valid", 64'(rp_valid), 64'd1);
    check(req, "rp_pc", 64'(rp_pc), 64'(pc));
    check(req, "rp_word", 64'(rp_word), 64'(word_of(pc)));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "rp_valid", 64'(rp_valid), 64'd0);
    check("R1", "fetch_hold", 64'(fetch_hold), 64'd0);
    rst_n = 1'b1;
    nxt();

    // Table walk: detect, watch, record with a stall, replay, stray inputs, flush.
    for (int i = 0; i < NV; i++) begin
      put(VT[i].fl, VT[i].st, VT[i].fd, 32'(VT[i].pc), VT[i].v, VT[i].t, 32'(VT[i].pc));
      check("R4/R5/R8/R9", "rp_valid", 64'(rp_valid), 64'(VT[i].ov));
      check("R4/R9", "fetch_hold", 64'(fetch_hold), 64'(VT[i].hold));
      if (VT[i].ov) begin
        check("R5 R6", "rp_pc", 64'(rp_pc), 64'(VT[i].epc));
        check("R6", "rp_word", 64'(rp_word), 64'(word_of(32'(VT[i].epc))));
      end
      nxt();
    end

    // R10: not-taken closing branch during recording abandons it.
    put(1'b0, 1'b0, 1'b1, 32'h400, 1'b0, 1'b0, '0); nxt();
    fetch(32'h400, 1'b1);
    fetch(32'h3F0, 1'b0);
    fetch(32'h400, 1'b0);
    fetch(32'h400, 1'b1);
    fetch(32'h3F0, 1'b0);
    fetch(32'h400, 1'b1);
    idle_cycle();
    check("R10", "fetch_hold", 64'(fetch_hold), 64'd0);
    check("R10", "rp_valid", 64'(rp_valid), 64'd0);
    nxt();

    // R7: a body of exactly DEPTH entries replays in full and wraps.
    put(1'b0, 1'b0, 1'b1, 32'h500, 1'b0, 1'b0, '0); nxt();
    fetch(32'h500, 1'b1);
    for (int k = 0; k < DEPTH - 1; k++) fetch(32'h480 + 32'(4 * k), 1'b0);
    fetch(32'h500, 1'b1);
    for (int k = 0; k <= DEPTH; k++) begin
      idle_cycle();
      check("R7", "fetch_hold", 64'(fetch_hold), 64'd1);
      if (k % DEPTH == DEPTH - 1) expect_entry("R7", 32'h500);
      else expect_entry("R7", 32'h480 + 32'(4 * (k % DEPTH)));
      nxt();
    end
    put(1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0); nxt();

    // R7: one entry too many abandons the recording.
    put(1'b0, 1'b0, 1'b1, 32'h600, 1'b0, 1'b0, '0); nxt();
    fetch(32'h600, 1'b1);
    for (int k = 0; k < DEPTH; k++) fetch(32'h580 + 32'(4 * k), 1'b0);
    fetch(32'h600, 1'b1);
    idle_cycle();
    check("R7", "overflow fetch_hold", 64'(fetch_hold), 64'd0);
    check("R7", "overflow rp_valid", 64'(rp_valid), 64'd0);
    nxt();

    // R9: flush during recording discards it.
    put(1'b0, 1'b0, 1'b1, 32'h700, 1'b0, 1'b0, '0); nxt();
    fetch(32'h700, 1'b1);
    fetch(32'h6F0, 1'b0);
    put(1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0); nxt();
    fetch(32'h6F4, 1'b0);
    fetch(32'h700, 1'b1);
    idle_cycle();
    check("R9", "fetch_hold after flush", 64'(fetch_hold), 64'd0);
    nxt();

    // R3: a not-taken match while watching does not start recording.
    put(1'b0, 1'b0, 1'b1, 32'h800, 1'b0, 1'b0, '0); nxt();
    fetch(32'h800, 1'b0);
    fetch(32'h7F0, 1'b0);
    fetch(32'h800, 1'b1);
    fetch(32'h7F8, 1'b0);
    fetch(32'h800, 1'b1);
    idle_cycle();
    expect_entry("R3", 32'h7F8);
    nxt();
    idle_cycle();
    expect_entry("R3", 32'h800);
    nxt();
    idle_cycle();
    expect_entry("R3", 32'h7F8);
    nxt();
    put(1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0); nxt();
    idle_cycle();
    check("R9", "fetch_hold idle", 64'(fetch_hold), 64'd0);

    finish_run();
  end

endmodule